// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates the interrupt requests of an 8-bit microcontroller core. It serves five sources: two external pins, two timer overflow requests and one serial-port request. The block holds the enable, priority and external-trigger control registers. Once per machine cycle, at the state-6 strobe from the core, it resolves the pending requests. A winner is accepted only when the core's blocking conditions allow it. The winner is then offered to the core as a vector call that carries a 16-bit entry address. The core pushes its PC and jumps to that address. The CPU datapath is outside this block.

Priority has two levels. Each source has one priority bit and there are two in-service flags, one per level. A source cannot interrupt a service routine of its own level or a higher level. Each external input can trigger on a falling edge or on a low level. After a return-from-interrupt, or after the core touches the enable or priority register, the core must finish one more instruction before any vector is taken.

The vector call is a valid/ready stream with one entry. The block raises `vec_valid` and holds `vec_addr` stable until the core asserts `vec_ready`. Polling stops while an offer is outstanding, so the core can stall acceptance for as long as it needs. A transfer takes place on the clock where `vec_valid` and `vec_ready` are both high. That clock sets the in-service flag for the winner's level. If the winner is an edge-triggered external source, the same clock clears its request flag. All other signals are plain level or pulse controls.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, all three registers read 0x00, `vec_valid` is low and `in_service` is 2'b00. An external input therefore starts in level mode.
- R2: A source can be offered only when its own enable bit and the global enable bit are both 1. In the enable register, bit 7 is the global enable and bits 4..0 are the per-source enables. Source indices are: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial.
- R3: The offered address is 0x0003 + 8 × (source index), so the addresses are 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R4: When several requests share a priority level, the lowest source index wins.
- R5: Any enabled high-level request beats every low-level request. Bits 4..0 of the priority register use the source indices, and a 1 means high level.
- R6: No offer is made while the in-service flag of the candidate's level, or of a higher level, is set. While only the low-level flag is set, a high-level request is still offered.
- R7: An offer is raised only on a state-6 strobe that arrives with `instr_last` high. It appears on the clock after that strobe.
- R8: Certain events block polling:
  - a `reti_done` pulse;
  - a write to the enable or priority register;
  - a `reg_rd` pulse that selects the enable or priority register.

  Each such event blocks polling at that strobe and at the instruction end that follows it. The next instruction end may then be offered.
- R9: In the external control register, bit 2e is the type of external input e (1 = edge, 0 = level) and bit 2e+1 is its request flag. In edge mode, a high-then-low sample across two strobes sets the flag, and acceptance of that source's vector clears it. In level mode, the flag copies the inverted pin at each strobe and acceptance leaves it unchanged. A flag sampled at one strobe takes part in the next strobe's poll.
- R10: While `vec_valid` is high and `vec_ready` is low, `vec_valid` stays high and `vec_addr` does not change, even if new or higher requests arrive. On acceptance, `in_service` gains the bit of the winner's level (bit 1 high, bit 0 low).
- R11: A `reti_done` pulse clears the high-level in-service bit if it is set. Otherwise it clears the low-level bit.
- R12: `reg_rdata` shows the register chosen by `reg_sel` (0 enable, 1 priority, 2 external control, 3 reads zero). Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s6_strobe | input | 1 | One-clock pulse at state 6 of each machine cycle |
| instr_last | input | 1 | With the strobe: this machine cycle ends the current instruction |
| reti_done | input | 1 | Pulse: the core executed a return-from-interrupt |
| ext_n | input | 2 | External interrupt pins, active low, synchronous |
| tmr_req | input | 2 | Timer 1/0 overflow requests, level |
| ser_req | input | 1 | Serial port request, level |
| reg_we | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (reports a read access) |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| vec_valid | output | 1 | Vector call offered |
| vec_ready | input | 1 | Core accepts the vector call |
| vec_addr | output | 16 | Entry address of the offered vector |
| in_service | output | 2 | In-service flags {high, low} |

## Verification
Faults in the arbitration state show up directly as an offered address that is wrong or missing. A wrong winner or level choice shows up one clock after the deciding strobe. A stuck in-service flag or hold flag only becomes visible at a later strobe, as an offer that is missing or arrives one instruction late. A flag that clears wrongly shows up on the external control register read-back before the next strobe. For these reasons the bench sweeps every request mask against every priority mask and checks each offer. It also walks the in-service, hold and trigger sequences step by step.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SRC_N   = 5;
  localparam int EXT_N   = 2;
  localparam int TMR_N   = 2;
  localparam int IDX_W   = $clog2(SRC_N);
  localparam int REG_W   = 8;
  localparam int GIE_BIT = 7;
  localparam logic [REG_W-1:0] ENA_MASK = 8'h9F;

  typedef logic [IDX_W-1:0] src_idx_t;

  typedef enum logic [1:0] {
    RSEL_ENA  = 2'd0,
    RSEL_PRI  = 2'd1,
    RSEL_EXT  = 2'd2,
    RSEL_NONE = 2'd3
  } rsel_e;
endpackage

// File: rtl/irq_ext_trigger.sv
module irq_ext_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic wr_en,
  input  logic wr_flag,
  input  logic ack_clr,
  output logic flag
);
  logic prev_q;
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
    end else if (sample) begin
      prev_q <= pin_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (wr_en) begin
      flag_q <= wr_flag;
    end else if (edge_mode) begin
      if (sample && prev_q && !pin_n) flag_q <= 1'b1;
      else if (ack_clr)               flag_q <= 1'b0;
    end else if (sample) begin
      flag_q <= !pin_n;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic [SRC_N-1:0] req,
  input  logic [SRC_N-1:0] prio,
  input  logic [1:0]       isr,
  output logic             hit,
  output logic             win_hi,
  output src_idx_t         win
);
  logic [SRC_N-1:0] hi_m;
  logic [SRC_N-1:0] lo_m;
  logic [SRC_N-1:0] sel_m;
  logic             hi_ok;
  logic             lo_ok;

  always_comb begin
    hi_m   = req & prio;
    lo_m   = req & ~prio;
    hi_ok  = (|hi_m) && !isr[1];
    lo_ok  = (|lo_m) && (isr == 2'b00);
    sel_m  = hi_ok ? hi_m : lo_m;
    hit    = hi_ok || lo_ok;
    win_hi = hi_ok;
    win    = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (sel_m[i]) win = src_idx_t'(i);
    end
  end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       take_hi,
  input  logic       reti,
  input  logic       ctl_acc,
  input  logic       instr_end,
  output logic [1:0] isr,
  output logic       block
);
  logic [1:0] isr_q;
  logic [1:0] isr_d;
  logic       hold_q;

  always_comb begin
    isr_d = isr_q;
    if (reti) begin
      if (isr_d[1]) isr_d[1] = 1'b0;
      else          isr_d[0] = 1'b0;
    end
    if (take) begin
      if (take_hi) isr_d[1] = 1'b1;
      else         isr_d[0] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= 2'b00;
      hold_q <= 1'b0;
    end else begin
      isr_q <= isr_d;
      if (reti || ctl_acc) hold_q <= 1'b1;
      else if (instr_end)  hold_q <= 1'b0;
    end
  end

  assign isr   = isr_q;
  assign block = hold_q || reti || ctl_acc;
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s6_strobe,
  input  logic              instr_last,
  input  logic              reti_done,
  input  logic [EXT_N-1:0]  ext_n,
  input  logic [TMR_N-1:0]  tmr_req,
  input  logic              ser_req,
  input  logic              reg_we,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              vec_valid,
  input  logic              vec_ready,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [1:0]        in_service
);
  rsel_e             sel;
  logic [REG_W-1:0]  en_q;
  logic [SRC_N-1:0]  prio_q;
  logic [EXT_N-1:0]  ext_type_q;
  logic [EXT_N-1:0]  ext_flag;
  logic [SRC_N-1:0]  src_raw;
  logic [SRC_N-1:0]  src_en;
  logic              ctl_acc;
  logic              take;
  logic              instr_end;
  logic              blocked;
  logic              hit;
  logic              win_hi;
  src_idx_t          win;
  logic              vec_valid_q;
  logic              vec_hi_q;
  src_idx_t          vec_src_q;
  logic [ADDR_W-1:0] vec_addr_q;
  logic [ADDR_W-1:0] next_addr;
  logic              poll_go;
  logic [1:0]        isr;

  assign sel       = rsel_e'(reg_sel);
  assign ctl_acc   = (reg_we || reg_rd) && (sel == RSEL_ENA || sel == RSEL_PRI);
  assign take      = vec_valid_q && vec_ready;
  assign instr_end = s6_strobe && instr_last;

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= '0;
      prio_q     <= '0;
      ext_type_q <= '0;
    end else if (reg_we) begin
      case (sel)
        RSEL_ENA: en_q   <= reg_wdata & ENA_MASK;
        RSEL_PRI: prio_q <= reg_wdata[SRC_N-1:0];
        RSEL_EXT: begin
          for (int e = 0; e < EXT_N; e++) ext_type_q[e] <= reg_wdata[2*e];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      RSEL_ENA: reg_rdata = en_q;
      RSEL_PRI: reg_rdata[SRC_N-1:0] = prio_q;
      RSEL_EXT: begin
        for (int e = 0; e < EXT_N; e++) begin
          reg_rdata[2*e]   = ext_type_q[e];
          reg_rdata[2*e+1] = ext_flag[e];
        end
      end
      default: reg_rdata = '0;
    endcase
  end

  // external triggers
  for (genvar e = 0; e < EXT_N; e++) begin : g_ext
    logic clr_e;
    assign clr_e = take && (vec_src_q == src_idx_t'(2*e));
    irq_ext_trigger u_trig (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample    (s6_strobe),
      .pin_n     (ext_n[e]),
      .edge_mode (ext_type_q[e]),
      .wr_en     (reg_we && sel == RSEL_EXT),
      .wr_flag   (reg_wdata[2*e+1]),
      .ack_clr   (clr_e),
      .flag      (ext_flag[e])
    );
  end

  // source map: even indices external, odd timers, last serial
  for (genvar s = 0; s < SRC_N; s++) begin : g_src
    if (s == SRC_N - 1) begin : g_ser
      assign src_raw[s] = ser_req;
    end else if (s % 2 == 0) begin : g_x
      assign src_raw[s] = ext_flag[s/2];
    end else begin : g_t
      assign src_raw[s] = tmr_req[s/2];
    end
  end

  assign src_en = src_raw & en_q[SRC_N-1:0] & {SRC_N{en_q[GIE_BIT]}};

  irq_arbiter u_arb (
    .req    (src_en),
    .prio   (prio_q),
    .isr    (isr),
    .hit    (hit),
    .win_hi (win_hi),
    .win    (win)
  );

  irq_inservice u_isr (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .take_hi   (vec_hi_q),
    .reti      (reti_done),
    .ctl_acc   (ctl_acc),
    .instr_end (instr_end),
    .isr       (isr),
    .block     (blocked)
  );

  assign next_addr = ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STRIDE) * ADDR_W'(win);
  assign poll_go   = instr_end && !blocked && !vec_valid_q && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid_q <= 1'b0;
      vec_hi_q    <= 1'b0;
      vec_src_q   <= '0;
      vec_addr_q  <= '0;
    end else if (poll_go) begin
      vec_valid_q <= 1'b1;
      vec_hi_q    <= win_hi;
      vec_src_q   <= win;
      vec_addr_q  <= next_addr;
    end else if (take) begin
      vec_valid_q <= 1'b0;
    end
  end

  assign vec_valid  = vec_valid_q;
  assign vec_addr   = vec_addr_q;
  assign in_service = isr;
endmodule

// File: rtl/irq_vec_ctrl_sva.sv
module irq_vec_ctrl_sva #(
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s6_strobe,
  input logic              instr_last,
  input logic              reti_done,
  input logic              reg_we,
  input logic              reg_rd,
  input logic [1:0]        reg_sel,
  input logic              vec_valid,
  input logic              vec_ready,
  input logic [ADDR_W-1:0] vec_addr,
  input logic [1:0]        in_service,
  input logic              gie
);
  p_addr_form_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ((vec_addr - ADDR_W'(VEC_BASE)) % ADDR_W'(VEC_STRIDE) == '0));

  p_gie_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> $past(gie));

  p_isr_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> !$past(in_service[1]));

  p_at_s6_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> $past(s6_strobe && instr_last));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> !$past(reti_done || ((reg_we || reg_rd) && reg_sel < 2'd2)));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_addr)));

  p_take_isr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready) |=> (in_service != 2'b00));

  p_reti_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_done && !(vec_valid && vec_ready) && in_service == 2'b11) |=> (in_service == 2'b01));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_sva #(
  .ADDR_W     (ADDR_W),
  .VEC_BASE   (VEC_BASE),
  .VEC_STRIDE (VEC_STRIDE)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .s6_strobe  (s6_strobe),
  .instr_last (instr_last),
  .reti_done  (reti_done),
  .reg_we     (reg_we),
  .reg_rd     (reg_rd),
  .reg_sel    (reg_sel),
  .vec_valid  (vec_valid),
  .vec_ready  (vec_ready),
  .vec_addr   (vec_addr),
  .in_service (in_service),
  .gie        (en_q[7])
);

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s6_strobe = 1'b0;
  logic        instr_last = 1'b0;
  logic        reti_done = 1'b0;
  logic [1:0]  ext_n = 2'b11;
  logic [1:0]  tmr_req = 2'b00;
  logic        ser_req = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_sel = 2'd3;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        vec_valid;
  logic        vec_ready = 1'b0;
  logic [15:0] vec_addr;
  logic [1:0]  in_service;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  irq_vec_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .s6_strobe(s6_strobe), .instr_last(instr_last),
    .reti_done(reti_done), .ext_n(ext_n), .tmr_req(tmr_req), .ser_req(ser_req),
    .reg_we(reg_we), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_addr(vec_addr), .in_service(in_service)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic mc(input logic last);
    s6_strobe = 1'b0; tick(); tick();
    s6_strobe = 1'b1; instr_last = last; tick();
    s6_strobe = 1'b0; instr_last = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1; tick();
    reg_we = 1'b0; reg_sel = 2'd3;
  endtask

  task automatic peek(input logic [1:0] sel, output logic [7:0] d);
    reg_sel = sel; #1 d = reg_rdata; reg_sel = 2'd3;
  endtask

  task automatic accept();
    vec_ready = 1'b1; tick(); vec_ready = 1'b0;
  endtask

  task automatic reti();
    reti_done = 1'b1; tick(); reti_done = 1'b0;
  endtask

  function automatic int exp_win(input logic [4:0] m, input logic [4:0] p);
    logic [4:0] s;
    s = ((m & p) != 0) ? (m & p) : m;
    for (int i = 0; i < 5; i++) if (s[i]) return i;
    return -1;
  endfunction

  initial begin
    #4000000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int w;
    repeat (3) tick();
    rst_n = 1'b1; tick();

    // R1 reset state, R12 read mux
    peek(2'd0, d); chk("R1 enable reg", d, 8'h00);
    peek(2'd1, d); chk("R1 prio reg", d, 8'h00);
    peek(2'd2, d); chk("R1 ext reg", d, 8'h00);
    chk("R1 vec_valid", vec_valid, 0);
    chk("R1 in_service", in_service, 0);
    wr(2'd0, 8'hFF); peek(2'd0, d); chk("R12 enable unused bits", d, 8'h9F);
    wr(2'd1, 8'hFF); peek(2'd1, d); chk("R12 prio unused bits", d, 8'h1F);
    peek(2'd3, d); chk("R12 sel 3 reads zero", d, 8'h00);
    wr(2'd1, 8'h00);

    // R2 global enable off
    wr(2'd0, 8'h1F); tmr_req = 2'b01;
    mc(1); mc(1); chk("R2 gie off", vec_valid, 0);
    // R2 source enable off
    wr(2'd0, 8'h80); mc(1); mc(1); chk("R2 source off", vec_valid, 0);

    // R7 only at instruction end
    wr(2'd0, 8'h9F); mc(1);
    mc(0); chk("R7 not last", vec_valid, 0);
    mc(0); chk("R7 not last again", vec_valid, 0);
    mc(1); chk("R7 last", vec_valid, 1); chk("R3 timer0 addr", vec_addr, 16'h000B);

    // R10 stall keeps offer
    ser_req = 1'b1;
    wr(2'd1, 8'h10);
    mc(1); mc(1);
    chk("R10 valid held", vec_valid, 1);
    chk("R10 addr held", vec_addr, 16'h000B);
    accept();
    chk("R10 drop after take", vec_valid, 0);
    chk("R10 low isr set", in_service, 2'b01);
    // R6 high allowed over low in service (serial high pending)
    mc(1); chk("R6 high preempts low", vec_addr, 16'h0023);
    chk("R6 high offered", vec_valid, 1);
    accept(); chk("R10 high isr set", in_service, 2'b11);
    mc(1); chk("R6 high in service blocks", vec_valid, 0);
    ser_req = 1'b0;
    reti(); chk("R11 clears high first", in_service, 2'b01);
    mc(1); mc(1); chk("R6 low in service blocks low", vec_valid, 0);
    reti(); chk("R11 clears low", in_service, 2'b00);
    mc(1); chk("R8 hold after reti", vec_valid, 0);
    mc(1); chk("R8 released after one instr", vec_valid, 1);
    accept(); tmr_req = 2'b00; reti(); mc(1);

    // R8 read of priority register blocks
    tmr_req = 2'b10;
    reg_sel = 2'd1; reg_rd = 1'b1; tick(); reg_rd = 1'b0; reg_sel = 2'd3;
    mc(1); chk("R8 hold after read", vec_valid, 0);
    mc(1); chk("R8 after read release", vec_addr, 16'h001B);
    accept(); tmr_req = 2'b00; reti(); mc(1);

    // R9 edge mode on external 0
    wr(2'd2, 8'h01);
    ext_n = 2'b11; mc(0);
    ext_n = 2'b10; mc(0);
    peek(2'd2, d); chk("R9 edge sets flag", d, 8'h03);
    mc(1); chk("R9 edge offer", vec_addr, 16'h0003); chk("R9 edge valid", vec_valid, 1);
    accept();
    peek(2'd2, d); chk("R9 edge flag cleared", d, 8'h01);
    reti(); mc(1); mc(1); chk("R9 no second edge", vec_valid, 0);
    // R9 level mode
    wr(2'd2, 8'h00); mc(1);
    peek(2'd2, d); chk("R9 level flag follows", d, 8'h02);
    mc(1); chk("R9 level offer", vec_addr, 16'h0003);
    accept();
    peek(2'd2, d); chk("R9 level flag kept", d, 8'h02);
    ext_n = 2'b11; reti(); mc(1);

    // R3 R4 R5 sweep over every request and priority mask
    for (int m = 0; m < 32; m++) begin
      for (int p = 0; p < 32; p++) begin
        logic [4:0] mm;
        logic [4:0] pp;
        mm = 5'(m); pp = 5'(p);
        wr(2'd1, {3'b000, pp});
        ext_n = ~{mm[2], mm[0]}; tmr_req = {mm[3], mm[1]}; ser_req = mm[4];
        mc(1);
        chk("R8 sweep hold", vec_valid, 0);
        mc(1);
        w = exp_win(mm, pp);
        if (w < 0) begin
          chk("R2 sweep no request", vec_valid, 0);
        end else begin
          chk("R4 R5 sweep valid", vec_valid, 1);
          chk("R3 R4 R5 sweep addr", vec_addr, 32'(3 + 8 * w));
          accept();
          chk("R10 sweep isr", in_service, ((mm & pp) != 0) ? 2'b10 : 2'b01);
        end
        ext_n = 2'b11; tmr_req = 2'b00; ser_req = 1'b0;
        reti();
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule